// File: doc/BRIEF.md
# Windowed Integer Register File

This block holds the integer registers of a processor core as a set of overlapping register windows. Each 5-bit architectural register number selects one of 32 registers: eight globals shared by every window, and eight outs, eight locals and eight ins that belong to the current window. A call-side shift (save) moves the current window so that the outs of the caller become the ins of the callee. A return-side shift (restore) moves it back, so values left in the callee's ins appear in the caller's outs.

Only a fixed number of windows exist in hardware. The block counts how many further saves and how many further restores can be served without touching memory. When a shift cannot be served, the window stays where it is and the block raises a one-cycle overflow or underflow trap request. Trap software then spills or refills a window, reports this on a spill-done or fill-done strobe, and retries the shift.

Top module: `winreg_file`

## Requirements
- R1: After synchronous reset, every register reads zero, the window is the initial one, and both trap outputs are 0.
- R2: Register 0 always reads zero on both read ports; a write to it has no effect.
- R3: Registers 1 to 7 are globals: a value written in one window reads back unchanged after any number of saves and restores.
- R4: After a successful save, ins 24..31 read the values the caller had in outs 8..15 (out 7, index 15, appears as in 7, index 31).
- R5: Locals 16..23 are private to each window: locals written by a callee do not change the caller's locals, and after a restore the caller's outs 8..15 read the callee's ins 24..31.
- R6: From reset, seven saves succeed; a save with no free window asserts ovf_trap for exactly the cycle after the request and leaves the window unchanged.
- R7: A restore with no resident older window asserts unf_trap for exactly the cycle after the request and leaves the window unchanged; a restore from reset does this.
- R8: A spill_done pulse makes one more save possible, and a fill_done pulse makes one more restore possible, so the retried shift then succeeds without a trap.
- R9: A read of the register being written in the same cycle returns the new write data on either read port.
- R10: When save_req and restore_req are both high, the save is performed and the restore is ignored; spill_done and fill_done are ignored in a cycle with either shift request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| rd_a_idx | input | 5 | Architectural register number, read port A |
| rd_b_idx | input | 5 | Architectural register number, read port B |
| rd_a_data | output | XLEN | Read data, port A (combinational) |
| rd_b_data | output | XLEN | Read data, port B (combinational) |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 5 | Architectural register number to write |
| wr_data | input | XLEN | Write data |
| save_req | input | 1 | Request a call-side window shift |
| restore_req | input | 1 | Request a return-side window shift |
| spill_done | input | 1 | Trap software has stored the oldest resident window |
| fill_done | input | 1 | Trap software has reloaded an older window |
| ovf_trap | output | 1 | Save could not be served (one cycle) |
| unf_trap | output | 1 | Restore could not be served (one cycle) |

## Verification
The assertions take for granted that spill_done is only pulsed when an older window is resident and fill_done only when a free window exists; the counters ignore them otherwise, so the assertions also hold if software misbehaves, but the pairing of counters is only meaningful under that discipline. They also assume reads and writes issued in the same cycle as a shift use the window in force before it. The stimulus keeps every strobe to a single cycle, issues spill and fill only after a trap has shown they are needed, and reads shifted registers only in cycles after the shift.

// File: rtl/winreg_pkg.sv
package winreg_pkg;

    // Register group selected by the two upper bits of an architectural index.
    typedef enum logic [1:0] {
        GRP_GLOB = 2'd0,
        GRP_OUT  = 2'd1,
        GRP_LOC  = 2'd2,
        GRP_IN   = 2'd3
    } grp_e;

    localparam int GRP_SIZE = 8;    // registers per group
    localparam int WIN_REGS = 16;   // physical registers owned by one window
    localparam int ARCH_W   = 5;

    // Outcome of a shift request in one cycle.
    typedef struct packed {
        logic shift_dn;   // save performed
        logic shift_up;   // restore performed
        logic ovf;        // save refused
        logic unf;        // restore refused
    } shift_res_t;

endpackage

// File: rtl/winreg_map.sv
module winreg_map
    import winreg_pkg::*;
#(
    parameter int NWIN   = 8,
    parameter int CWP_W  = $clog2(NWIN),
    parameter int PIDX_W = $clog2(GRP_SIZE + NWIN * WIN_REGS)
) (
    input  logic [ARCH_W-1:0] arch_idx,
    input  logic [CWP_W-1:0]  cwp,
    output logic [PIDX_W-1:0] phys_idx
);
    grp_e             grp;
    logic [CWP_W-1:0] win;
    int               base;

    always_comb begin
        grp  = grp_e'(arch_idx[4:3]);
        win  = cwp;
        // Outs of window w are the ins of the window a save moves to (w-1).
        if (grp == GRP_OUT)
            win = (cwp == '0) ? CWP_W'(NWIN - 1) : cwp - 1'b1;
        base = GRP_SIZE + int'(win) * WIN_REGS;
        case (grp)
            GRP_GLOB: phys_idx = PIDX_W'(int'(arch_idx[2:0]));
            GRP_LOC:  phys_idx = PIDX_W'(base + int'(arch_idx[2:0]));
            default:  phys_idx = PIDX_W'(base + GRP_SIZE + int'(arch_idx[2:0]));
        endcase
    end
endmodule

// File: rtl/winreg_ctl.sv
module winreg_ctl
    import winreg_pkg::*;
#(
    parameter int NWIN  = 8,
    parameter int CWP_W = $clog2(NWIN),
    parameter int CNT_W = $clog2(NWIN + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             save_req,
    input  logic             restore_req,
    input  logic             spill_done,
    input  logic             fill_done,
    output logic [CWP_W-1:0] cwp,
    output logic             ovf_trap,
    output logic             unf_trap
);
    localparam logic [CNT_W-1:0] AVAIL = CNT_W'(NWIN - 1);

    logic [CNT_W-1:0] savable, restorable;
    shift_res_t       res;
    logic             do_spill, do_fill;

    always_comb begin
        res = '0;
        if (save_req) begin
            if (savable == '0) res.ovf = 1'b1;
            else               res.shift_dn = 1'b1;
        end else if (restore_req) begin
            if (restorable == '0) res.unf = 1'b1;
            else                  res.shift_up = 1'b1;
        end
        do_spill = !save_req && !restore_req && spill_done && (restorable != '0);
        do_fill  = !save_req && !restore_req && !spill_done && fill_done && (savable != '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cwp        <= '0;
            savable    <= AVAIL;
            restorable <= '0;
            ovf_trap   <= 1'b0;
            unf_trap   <= 1'b0;
        end else begin
            ovf_trap <= res.ovf;
            unf_trap <= res.unf;
            if (res.shift_dn) begin
                cwp        <= (cwp == '0) ? CWP_W'(NWIN - 1) : cwp - 1'b1;
                savable    <= savable - 1'b1;
                restorable <= restorable + 1'b1;
            end else if (res.shift_up) begin
                cwp        <= (cwp == CWP_W'(NWIN - 1)) ? '0 : cwp + 1'b1;
                savable    <= savable + 1'b1;
                restorable <= restorable - 1'b1;
            end else if (do_spill) begin
                savable    <= savable + 1'b1;
                restorable <= restorable - 1'b1;
            end else if (do_fill) begin
                savable    <= savable - 1'b1;
                restorable <= restorable + 1'b1;
            end
        end
    end

    // R6/R8: one window is always held back, the two counts share the rest.
    a_r6_window_budget: assert property (@(posedge clk) disable iff (rst)
        (savable + restorable) == AVAIL);
    a_r6_no_overflow: assert property (@(posedge clk) disable iff (rst)
        (save_req && savable == '0) |=> (ovf_trap && cwp == $past(cwp)));
    a_r7_no_underflow: assert property (@(posedge clk) disable iff (rst)
        (!save_req && restore_req && restorable == '0) |=> (unf_trap && cwp == $past(cwp)));
    a_r4_save_moves: assert property (@(posedge clk) disable iff (rst)
        (save_req && savable != '0) |=> (!ovf_trap && cwp != $past(cwp)));
    a_r10_single_trap: assert property (@(posedge clk) disable iff (rst)
        !(ovf_trap && unf_trap));
endmodule

// File: rtl/winreg_store.sv
module winreg_store
    import winreg_pkg::*;
#(
    parameter int NWIN   = 8,
    parameter int XLEN   = 32,
    parameter int PHYS   = GRP_SIZE + NWIN * WIN_REGS,
    parameter int PIDX_W = $clog2(PHYS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [PIDX_W-1:0] rd_a_p,
    input  logic [PIDX_W-1:0] rd_b_p,
    output logic [XLEN-1:0]   rd_a_data,
    output logic [XLEN-1:0]   rd_b_data,
    input  logic              wr_en,
    input  logic [PIDX_W-1:0] wr_p,
    input  logic [XLEN-1:0]   wr_data
);
    logic [XLEN-1:0]   mem [PHYS];
    logic              wr_live;
    logic [PIDX_W-1:0] rp   [2];
    logic [XLEN-1:0]   rdat [2];

    assign wr_live = wr_en && (wr_p != '0);   // physical 0 is the zero register
    assign rp[0]   = rd_a_p;
    assign rp[1]   = rd_b_p;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < PHYS; i++) mem[i] <= '0;
        end else if (wr_live) begin
            mem[wr_p] <= wr_data;
        end
    end

    for (genvar p = 0; p < 2; p++) begin : g_rd
        always_comb begin
            if (wr_live && wr_p == rp[p]) rdat[p] = wr_data;
            else                          rdat[p] = mem[rp[p]];
        end
    end

    assign rd_a_data = rdat[0];
    assign rd_b_data = rdat[1];

    a_r2_zero_port_a: assert property (@(posedge clk) disable iff (rst)
        (rd_a_p == '0) |-> (rd_a_data == '0));
    a_r2_zero_port_b: assert property (@(posedge clk) disable iff (rst)
        (rd_b_p == '0) |-> (rd_b_data == '0));
    a_r9_write_lands: assert property (@(posedge clk) disable iff (rst)
        (wr_live && !$isunknown(wr_data)) |=> (mem[$past(wr_p)] == $past(wr_data)));
endmodule

// File: rtl/winreg_file.sv
module winreg_file
    import winreg_pkg::*;
#(
    parameter int NWIN = 8,
    parameter int XLEN = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ARCH_W-1:0] rd_a_idx,
    input  logic [ARCH_W-1:0] rd_b_idx,
    output logic [XLEN-1:0]   rd_a_data,
    output logic [XLEN-1:0]   rd_b_data,
    input  logic              wr_en,
    input  logic [ARCH_W-1:0] wr_idx,
    input  logic [XLEN-1:0]   wr_data,
    input  logic              save_req,
    input  logic              restore_req,
    input  logic              spill_done,
    input  logic              fill_done,
    output logic              ovf_trap,
    output logic              unf_trap
);
    localparam int PHYS   = GRP_SIZE + NWIN * WIN_REGS;
    localparam int PIDX_W = $clog2(PHYS);
    localparam int CWP_W  = $clog2(NWIN);

    logic [CWP_W-1:0]  cwp;
    logic [ARCH_W-1:0] aidx [3];
    logic [PIDX_W-1:0] pidx [3];

    assign aidx[0] = rd_a_idx;
    assign aidx[1] = rd_b_idx;
    assign aidx[2] = wr_idx;

    winreg_ctl #(.NWIN(NWIN)) u_ctl (
        .clk(clk), .rst(rst),
        .save_req(save_req), .restore_req(restore_req),
        .spill_done(spill_done), .fill_done(fill_done),
        .cwp(cwp), .ovf_trap(ovf_trap), .unf_trap(unf_trap)
    );

    for (genvar g = 0; g < 3; g++) begin : g_map
        winreg_map #(.NWIN(NWIN), .CWP_W(CWP_W), .PIDX_W(PIDX_W)) u_map (
            .arch_idx(aidx[g]), .cwp(cwp), .phys_idx(pidx[g])
        );
    end

    winreg_store #(.NWIN(NWIN), .XLEN(XLEN), .PHYS(PHYS), .PIDX_W(PIDX_W)) u_store (
        .clk(clk), .rst(rst),
        .rd_a_p(pidx[0]), .rd_b_p(pidx[1]),
        .rd_a_data(rd_a_data), .rd_b_data(rd_b_data),
        .wr_en(wr_en), .wr_p(pidx[2]), .wr_data(wr_data)
    );
endmodule

// File: tb/winreg_file_test.sv
module winreg_file_test;
    logic        clk = 1'b0;
    logic        rst;
    logic [4:0]  rd_a_idx, rd_b_idx, wr_idx;
    logic [31:0] rd_a_data, rd_b_data, wr_data;
    logic        wr_en, save_req, restore_req, spill_done, fill_done;
    logic        ovf_trap, unf_trap;
    int          checks = 0;
    int          errors = 0;

    always #4 clk = ~clk;   // 125 MHz

    winreg_file uut (
        .clk(clk), .rst(rst),
        .rd_a_idx(rd_a_idx), .rd_b_idx(rd_b_idx),
        .rd_a_data(rd_a_data), .rd_b_data(rd_b_data),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .save_req(save_req), .restore_req(restore_req),
        .spill_done(spill_done), .fill_done(fill_done),
        .ovf_trap(ovf_trap), .unf_trap(unf_trap)
    );

    // Vector: {op, req, idx, value}; op 0 write, 1 read-check, 2 save, 3 restore.
    localparam int NVEC = 13;
    localparam logic [42:0] VEC [NVEC] = '{
        {2'd0, 4'd3,  5'd1,  32'h1111_0001},  // R3 write g1
        {2'd0, 4'd4,  5'd15, 32'h0000_00AB},  // R4 write o7
        {2'd0, 4'd5,  5'd16, 32'h0000_0055},  // R5 caller l0
        {2'd2, 4'd4,  5'd0,  32'h0},          // R4 save
        {2'd1, 4'd4,  5'd31, 32'h0000_00AB},  // R4 o7 -> i7
        {2'd1, 4'd3,  5'd1,  32'h1111_0001},  // R3 global shared
        {2'd1, 4'd5,  5'd16, 32'h0},          // R5 fresh locals
        {2'd0, 4'd5,  5'd16, 32'h0000_0077},  // R5 callee l0
        {2'd0, 4'd5,  5'd24, 32'h0000_0099},  // R5 callee i0
        {2'd3, 4'd5,  5'd0,  32'h0},          // R5 restore
        {2'd1, 4'd5,  5'd16, 32'h0000_0055},  // R5 caller local kept
        {2'd1, 4'd5,  5'd8,  32'h0000_0099},  // R5 return value in o0
        {2'd1, 4'd3,  5'd1,  32'h1111_0001}   // R3 global after restore
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
        wr_en = 0; save_req = 0; restore_req = 0; spill_done = 0; fill_done = 0;
    endtask

    task automatic do_reset();
        rst = 1;
        tick();
        tick();
        rst = 0;
    endtask

    task automatic wr(input logic [4:0] idx, input logic [31:0] val);
        wr_en = 1; wr_idx = idx; wr_data = val;
        tick();
    endtask

    task automatic rd(input string req, input logic [4:0] idx, input logic [31:0] exp);
        rd_a_idx = idx;
        #1;
        check(req, rd_a_data, exp);
    endtask

    initial begin
        #(200000 * 8);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        wr_en = 0; save_req = 0; restore_req = 0; spill_done = 0; fill_done = 0;
        rd_a_idx = 0; rd_b_idx = 0; wr_idx = 0; wr_data = 0;
        do_reset();

        // R1 reset state
        rd("R1", 5'd13, 32'h0);
        rd("R1", 5'd30, 32'h0);
        check("R1 ovf", {31'b0, ovf_trap}, 32'h0);
        check("R1 unf", {31'b0, unf_trap}, 32'h0);

        // Vector table
        for (int i = 0; i < NVEC; i++) begin
            case (VEC[i][42:41])
                2'd0: wr(VEC[i][36:32], VEC[i][31:0]);
                2'd1: rd($sformatf("R%0d vec%0d", VEC[i][40:37], i), VEC[i][36:32], VEC[i][31:0]);
                2'd2: begin save_req = 1; tick(); end
                default: begin restore_req = 1; tick(); end
            endcase
        end

        // R2 zero register
        wr(5'd0, 32'hFFFF_FFFF);
        rd_b_idx = 0;
        rd("R2 port a", 5'd0, 32'h0);
        check("R2 port b", rd_b_data, 32'h0);

        // R9 write-first bypass on both ports
        wr_en = 1; wr_idx = 5'd5; wr_data = 32'h1234_5678;
        rd_b_idx = 5'd5;
        rd("R9 port a", 5'd5, 32'h1234_5678);
        check("R9 port b", rd_b_data, 32'h1234_5678);
        tick();

        // R7 underflow from reset, then R8 fill
        do_reset();
        wr(5'd8, 32'h42);
        wr(5'd24, 32'h24);
        restore_req = 1; tick();
        check("R7 unf", {31'b0, unf_trap}, 32'h1);
        rd("R7 window kept o0", 5'd8, 32'h42);
        rd("R7 window kept i0", 5'd24, 32'h24);
        tick();
        check("R7 one cycle", {31'b0, unf_trap}, 32'h0);
        fill_done = 1; tick();
        restore_req = 1; tick();
        check("R8 fill then restore", {31'b0, unf_trap}, 32'h0);
        rd("R8 restored o0", 5'd8, 32'h24);

        // R10 simultaneous save and restore
        do_reset();
        wr(5'd8, 32'h5);
        save_req = 1; restore_req = 1; tick();
        check("R10 no unf", {31'b0, unf_trap}, 32'h0);
        check("R10 no ovf", {31'b0, ovf_trap}, 32'h0);
        rd("R10 save taken", 5'd24, 32'h5);

        // R6 overflow after seven saves, R8 spill
        do_reset();
        for (int s = 0; s < 7; s++) begin
            save_req = 1; tick();
            check($sformatf("R6 save %0d", s), {31'b0, ovf_trap}, 32'h0);
        end
        wr(5'd8, 32'h66);
        save_req = 1; tick();
        check("R6 ovf", {31'b0, ovf_trap}, 32'h1);
        rd("R6 window kept", 5'd8, 32'h66);
        tick();
        check("R6 one cycle", {31'b0, ovf_trap}, 32'h0);
        save_req = 1; spill_done = 1; tick();
        check("R10 spill ignored with save", {31'b0, ovf_trap}, 32'h1);
        save_req = 1; tick();
        check("R10 still full", {31'b0, ovf_trap}, 32'h1);
        spill_done = 1; tick();
        save_req = 1; tick();
        check("R8 spill then save", {31'b0, ovf_trap}, 32'h0);
        rd("R8 saved i0", 5'd24, 32'h66);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule